// File: doc/BRIEF.md
# Synthesizer divider configuration loader

This block holds the control word of a clock synthesizer: a 9-bit feedback divider value M, which sets the VCO to M times the reference, and a 2-bit output divider select N. Two paths can write the word.

The parallel path is controlled by an active-low strobe. While the strobe is low, the outputs track the parallel pins. When the strobe rises, the pins are captured and the value is held. Pins tied to fixed levels therefore give a power-up default.

The serial path is a three-wire shifter with a shift clock, a data line and a load line. It can replace the held value whenever the strobe is high. A test output shows the serial bit stream, and a flag reports whether the loaded M lies in the range where the loop can lock.

All inputs are asynchronous to the block clock. Each input passes through a two-flop synchronizer, and all edges are detected in the block clock domain.

Top module: `synth_cfg_loader`

## Requirements
- R1: Master reset (`rst`, synchronous, active high) clears the 11-bit shift register and the shifted-out bit. It loads `m_out`/`n_out` from the current parallel pins, drives `test_out` low, and sets `m_valid` for the pin value of M.
- R2: While `par_load_n` is low, `m_out` and `n_out` follow `par_m` and `par_n`, each as the exact unsigned binary value of the pins.
- R3: On the rising edge of `par_load_n` the parallel pins are captured. Later pin changes have no effect on the outputs while the strobe stays high and no serial load occurs.
- R4: Each rising edge of `ser_clk` shifts `ser_data` into an 11-bit register, most significant bit first, in the order N1, N0, M8 down to M0. A rising edge of `ser_load` while the strobe is high copies that register to the outputs: bits 10:9 go to N and bits 8:0 go to M.
- R5: A rising edge of `ser_load` while `par_load_n` is low has no effect; the outputs keep following the pins.
- R6: `test_out` is low whenever the synchronized strobe is low.
- R7: While the strobe is high, `test_out` equals the bit most recently shifted out of the top of the shift register.
- R8: `m_valid` is high exactly when `M_MIN <= m_out <= M_MAX`, with defaults 10 and 28.
- R9: A change on a parallel pin reaches the outputs on the third rising clock edge after it: two synchronizer stages plus the output register.
- R10: A later low level on `par_load_n` replaces a serially loaded value with the parallel pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high master reset |
| par_load_n | input | 1 | Parallel load strobe, active low, asynchronous |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider select |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on shift clock rise |
| ser_load | input | 1 | Serial transfer strobe, active on rising edge |
| m_out | output | 9 | Active feedback divider value |
| n_out | output | 2 | Active output divider select |
| test_out | output | 1 | Low in parallel mode, shifted-out bit in serial mode |
| m_valid | output | 1 | M lies inside the lock range |

## Verification
The hardest case to reach is the bit shown on `test_out` in serial mode. It only differs from zero once a full 11-bit word has been pushed through, and a second word is being shifted in behind it. The stimulus therefore shifts two different words back to back, with the strobe held high.

A further hard case is a serial load pulse issued while the strobe is low, which must be shown to do nothing. The stimulus then raises the strobe and issues a proper load, so that the difference between the pins and the shift register becomes visible on the outputs.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int CFG_W = M_W + N_W;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/scl_sync2.sv
module scl_sync2 #(
  parameter int W = 1,
  parameter bit RST_EN = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  generate
    if (RST_EN) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= RST_VAL;
          q      <= RST_VAL;
        end else begin
          stage1 <= d;
          q      <= stage1;
        end
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        stage1 <= d;
        q      <= stage1;
      end
    end
  endgenerate
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdat_s,
  input  logic         sload_s,
  output logic [W-1:0] sreg,
  output logic         load_rise,
  output logic         tbit_nxt
);
  logic sclk_prev;
  logic load_prev;
  logic out_bit;
  logic shift_rise;

  assign shift_rise = sclk_s & ~sclk_prev;
  assign load_rise  = sload_s & ~load_prev;
  assign tbit_nxt   = shift_rise ? sreg[W-1] : out_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      load_prev <= 1'b0;
      sreg      <= '0;
      out_bit   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      load_prev <= sload_s;
      if (shift_rise) begin
        out_bit <= sreg[W-1];
        sreg    <= {sreg[W-2:0], sdat_s};
      end
    end
  end
endmodule

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_MIN = M_W'(10),
  parameter logic [M_W-1:0] M_MAX = M_W'(28)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_s,
  input  cfg_t             par_s,
  input  cfg_t             par_raw,
  input  logic [CFG_W-1:0] ser_word,
  input  logic             load_rise,
  input  logic             tbit_nxt,
  output cfg_t             cfg_q,
  output logic             stb_prev,
  output logic             m_valid,
  output logic             test_out
);
  cfg_t nxt;

  function automatic logic in_range(input logic [M_W-1:0] v);
    return (v >= M_MIN) && (v <= M_MAX);
  endfunction

  always_comb begin
    nxt = cfg_q;
    if (!stb_s || !stb_prev) nxt = par_s;
    else if (load_rise) nxt = cfg_t'(ser_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= par_raw;
      stb_prev <= 1'b1;
      m_valid  <= in_range(par_raw.m);
      test_out <= 1'b0;
    end else begin
      cfg_q    <= nxt;
      stb_prev <= stb_s;
      m_valid  <= in_range(nxt.m);
      test_out <= stb_s ? tbit_nxt : 1'b0;
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_MIN = M_W'(10),
  parameter logic [M_W-1:0] M_MAX = M_W'(28)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic           test_out,
  output logic           m_valid
);
  logic             stb_s;
  logic             stb_prev;
  cfg_t             par_raw;
  cfg_t             par_s;
  logic [1:0]       sctl_s;
  logic             sdat_s;
  logic [CFG_W-1:0] ser_word;
  logic             load_rise;
  logic             tbit_nxt;
  cfg_t             cfg_q;

  assign par_raw = '{n: par_n, m: par_m};

  scl_sync2 #(.W(1), .RST_EN(1'b1), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst(rst), .d(par_load_n), .q(stb_s));

  scl_sync2 #(.W(CFG_W), .RST_EN(1'b0), .RST_VAL('0)) u_sync_par (
    .clk(clk), .rst(rst), .d(par_raw), .q(par_s));

  scl_sync2 #(.W(2), .RST_EN(1'b1), .RST_VAL(2'b00)) u_sync_sctl (
    .clk(clk), .rst(rst), .d({ser_load, ser_clk}), .q(sctl_s));

  scl_sync2 #(.W(1), .RST_EN(1'b0), .RST_VAL(1'b0)) u_sync_sdat (
    .clk(clk), .rst(rst), .d(ser_data), .q(sdat_s));

  scl_shifter #(.W(CFG_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sctl_s[0]), .sdat_s(sdat_s),
    .sload_s(sctl_s[1]), .sreg(ser_word), .load_rise(load_rise),
    .tbit_nxt(tbit_nxt));

  scl_cfg_reg #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_cfg (
    .clk(clk), .rst(rst), .stb_s(stb_s), .par_s(par_s), .par_raw(par_raw),
    .ser_word(ser_word), .load_rise(load_rise), .tbit_nxt(tbit_nxt),
    .cfg_q(cfg_q), .stb_prev(stb_prev), .m_valid(m_valid),
    .test_out(test_out));

  assign m_out = cfg_q.m;
  assign n_out = cfg_q.n;
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
  import synth_cfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_MIN = M_W'(10),
  parameter logic [M_W-1:0] M_MAX = M_W'(28)
) (
  input logic             clk,
  input logic             rst,
  input logic             stb_s,
  input logic             stb_prev,
  input cfg_t             par_s,
  input logic [CFG_W-1:0] ser_word,
  input logic             load_rise,
  input logic [M_W-1:0]   m_out,
  input logic [N_W-1:0]   n_out,
  input logic             test_out,
  input logic             m_valid
);
  assert_follow_pins_R2: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> ({n_out, m_out} == $past(par_s)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (stb_s && stb_prev && !load_rise) |=> ($stable(m_out) && $stable(n_out)));

  assert_serial_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    (stb_s && stb_prev && load_rise) |=> ({n_out, m_out} == $past(ser_word)));

  assert_load_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!stb_s && load_rise) |=> (n_out == $past(par_s.n)));

  assert_test_low_R6: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> !test_out);

  assert_valid_range_R8: assert property (@(posedge clk) disable iff (rst)
    m_valid == ((m_out >= M_MIN) && (m_out <= M_MAX)));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk(clk), .rst(rst), .stb_s(stb_s), .stb_prev(stb_prev), .par_s(par_s),
  .ser_word(ser_word), .load_rise(load_rise), .m_out(m_out), .n_out(n_out),
  .test_out(test_out), .m_valid(m_valid));

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_load_n = 1'b1;
  logic [8:0] par_m = 9'd20;
  logic [1:0] par_n = 2'd1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic test_out, m_valid;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit started = 0;

  always #2.5 clk = ~clk;

  synth_cfg_loader u_dut (
    .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_out(n_out), .test_out(test_out), .m_valid(m_valid));

  function automatic bit inr(input int v);
    return (v >= 10) && (v <= 28);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: two-stage sampling delay, then the load rules
  bit ps1, ps2, pprev, c1, c2, cprev, d1, d2, l1, l2, lprev, mob, mtest, mvalid;
  bit [10:0] pd1, pd2, msr, mcfg;

  always @(posedge clk) begin
    bit sr, lr, tb;
    bit [10:0] nc;
    if (rst) begin
      ps1 = 1; ps2 = 1; pprev = 1;
      c1 = 0; c2 = 0; cprev = 0; l1 = 0; l2 = 0; lprev = 0;
      pd2 = pd1; pd1 = {par_n, par_m}; d2 = d1; d1 = ser_data;
      msr = 0; mob = 0; mcfg = {par_n, par_m}; mvalid = inr(int'(par_m)); mtest = 0;
    end else begin
      sr = c2 && !cprev;
      lr = l2 && !lprev;
      nc = mcfg;
      if (!ps2 || !pprev) nc = pd2;
      else if (lr) nc = msr;
      tb = sr ? msr[10] : mob;
      mtest = ps2 ? tb : 1'b0;
      mcfg = nc;
      mvalid = inr(int'(nc[8:0]));
      if (sr) begin
        mob = msr[10];
        msr = {msr[9:0], d2};
      end
      pprev = ps2; ps2 = ps1; ps1 = par_load_n;
      pd2 = pd1; pd1 = {par_n, par_m};
      cprev = c2; c2 = c1; c1 = ser_clk;
      d2 = d1; d1 = ser_data;
      lprev = l2; l2 = l1; l1 = ser_load;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk(phase, "model m_out", int'(m_out), int'(mcfg[8:0]));
      chk(phase, "model n_out", int'(n_out), int'(mcfg[10:9]));
      chk(phase, "model test_out", int'(test_out), int'(mtest));
      chk(phase, "model m_valid", int'(m_valid), int'(mvalid));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b);
    ser_data = b; tick(3);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic sword(input bit [10:0] w);
    for (int i = 10; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic spulse();
    ser_load = 1'b1; tick(4);
    ser_load = 1'b0; tick(4);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[6] = '{5, 28, 29, 10, 9, 511};
    tick(5);
    started = 1;
    rst = 1'b0;
    tick(1);
    chk("R1", "m after reset", int'(m_out), 20);
    chk("R1", "n after reset", int'(n_out), 1);
    chk("R1", "test after reset", int'(test_out), 0);
    chk("R8", "valid after reset", int'(m_valid), 1);

    phase = "R2";
    par_load_n = 1'b0; tick(5);
    foreach (vals[i]) begin
      par_m = 9'(vals[i]); par_n = 2'(i); tick(6);
      chk("R2", "m follows pins", int'(m_out), vals[i]);
      chk("R2", "n follows pins", int'(n_out), i % 4);
      chk("R6", "test low in parallel", int'(test_out), 0);
      chk("R8", "valid range", int'(m_valid), int'(inr(vals[i])));
    end

    phase = "R9";
    par_m = 9'd100; tick(2);
    chk("R9", "m before third edge", int'(m_out), 511);
    tick(1);
    chk("R9", "m at third edge", int'(m_out), 100);

    phase = "R3";
    par_m = 9'd171; par_n = 2'd0; tick(5);
    par_load_n = 1'b1; tick(5);
    par_m = 9'd33; par_n = 2'd3; tick(8);
    chk("R3", "m held", int'(m_out), 171);
    chk("R3", "n held", int'(n_out), 0);

    phase = "R4";
    sword(11'h40F);
    chk("R1", "shift cleared by reset", int'(test_out), 0);
    spulse();
    chk("R4", "serial m", int'(m_out), 15);
    chk("R4", "serial n", int'(n_out), 2);
    chk("R8", "serial valid", int'(m_valid), 1);

    phase = "R7";
    sword({2'd3, 9'd27});
    chk("R7", "shifted-out bit", int'(test_out), 1);
    spulse();
    chk("R4", "second serial m", int'(m_out), 27);
    chk("R4", "second serial n", int'(n_out), 3);

    phase = "R5";
    par_load_n = 1'b0; tick(6);
    chk("R6", "test low again", int'(test_out), 0);
    sword(11'h055);
    spulse();
    chk("R5", "load ignored m", int'(m_out), 33);
    chk("R5", "load ignored n", int'(n_out), 3);
    par_load_n = 1'b1; tick(6);
    chk("R3", "capture pins not shifter", int'(m_out), 33);

    phase = "R10";
    spulse();
    chk("R4", "third serial m", int'(m_out), 85);
    par_load_n = 1'b0; tick(6);
    chk("R10", "strobe low overrides serial", int'(m_out), 33);
    chk("R10", "n overridden", int'(n_out), 3);

    phase = "R1";
    par_load_n = 1'b1; tick(5);
    par_m = 9'd12; par_n = 2'd2; tick(3);
    rst = 1'b1; tick(4);
    rst = 1'b0; tick(1);
    chk("R1", "m after second reset", int'(m_out), 12);
    chk("R1", "n after second reset", int'(n_out), 2);
    chk("R1", "test after second reset", int'(test_out), 0);
    sbit(1'b1);
    chk("R1", "shifted-out bit zero after reset", int'(test_out), 0);
    tick(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule